// File: doc/BRIEF.md
# Banked Packet-Buffer Host Window

This block is the host-facing register window of a packet buffer controller. The host sees sixteen byte locations. A bank register, present at the same offset in every bank, chooses which of four register sets the other offsets reach. Bank 2 holds a 16-bit buffer pointer and a four-byte data window. Host accesses to the data window read or write the buffer RAM inside the block. The upper pointer bits choose the page: either the page at the head of the receive queue or the page named in the packet-number register. Another pointer bit turns on auto-increment. The same bank holds the interrupt status, mask and acknowledge registers, and the block drives one interrupt line from them.

Host requests use a valid/ready handshake. A request is accepted only while `req_ready` is high, and the block takes one request at a time. A 16-bit or 32-bit request is carried out as a series of single-byte operations at ascending offsets, and each byte operation takes two cycles. The response stays on `rsp_valid`/`rsp_rdata` until the host raises `rsp_ready`. The allocator and the queues lie outside the block. They supply the head-of-queue page numbers, the queue-empty flags and the event pulses. The block returns pulses for MMU commands, completion-queue pops and soft reset.

Top module: `bufport_window`

## Requirements
- R1: Offset 14 is the bank register in all banks, readable and writable, and bits 1:0 pick the bank. Offset 15 always reads 0x33, and a write to offset 15 changes nothing.
- R2: In bank 2, data window offsets 8..11 reach the buffer page given by `rx_head` when pointer bit 15 is 1, and the page given by the packet-number register (bank 2, offset 2) when bit 15 is 0.
- R3: When pointer bit 14 is 1, every data-window byte access uses pointer bits 10:0 as the byte address and then adds one to bits 10:0 modulo 2048. Bits 15:11 do not change.
- R4: When pointer bit 14 is 0, the byte address is pointer bits 10:0 plus (offset mod 4), wrapping within the 2048-byte page, and the pointer does not change.
- R5: The pointer is at bank 2 offsets 6 (low byte) and 7 (high byte). The high byte reads back ANDed with 0xF7.
- R6: A write of value V to bank 2 offset 12 clears the status bits in V & 0xD6. When V bit 1 is set, it also gives one `done_pop` pulse.
- R7: `irq` is the OR of status AND mask, where mask is bank 2 offset 13 and status is bank 2 offset 12. Status bit 2 is set whenever `txq_empty` is 1, and status bit 1 is set whenever `done_empty` is 0. Both bits stay set until they are acknowledged.
- R8: A 16-bit access covers the address and then the address + 1. A 32-bit access covers four ascending offsets, and offsets wrap modulo 16. The one exception is a 32-bit write at offset 12, which writes only offsets 14 and 15.
- R9: After reset the bank is 0, the configuration register (bank 1, offsets 0/1) is 0xA0B1, the control register (bank 1, offsets 12/13) is 0x1210, the early-receive register (bank 3, offset 12) is 0x1F, status is 0x04 and mask is 0.
- R10: Writing a high byte with bit 7 set to the receive-control register (bank 0, offset 5) gives one `soft_rst` pulse and puts every register back to its R9 value.
- R11: `req_ready` is high only when no request is in flight. `rsp_valid` rises 2N clock edges after the accepting edge, where N is the number of byte operations. The response stays valid and unchanged until `rsp_ready` is high.
- R12: A write to bank 2 offset 0 gives one `mmu_cmd_valid` pulse, with the byte on `mmu_cmd`. A write to the control low byte clears bits 1:0 of the written value. A write to the early-receive register keeps only bits 4:0.
- R13: An `evt_set` bit sets its status bit and an `evt_clr` bit clears it. Status bits 0, 3 and 5 can be cleared only through `evt_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset in the window |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data, byte lane k goes to offset addr+k |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read data, lane k from offset addr+k |
| rx_head | input | 8 | Page number at the receive-queue head |
| rx_empty | input | 1 | Receive queue empty |
| done_head | input | 8 | Page number at the completion-queue head |
| done_empty | input | 1 | Completion queue empty |
| alloc_result | input | 8 | Result of the last allocation |
| txq_empty | input | 1 | Transmit queue empty |
| evt_set | input | 8 | Status bits to set, one cycle per pulse |
| evt_clr | input | 8 | Status bits to clear, one cycle per pulse |
| irq | output | 1 | Interrupt request |
| mmu_cmd_valid | output | 1 | MMU command byte written |
| mmu_cmd | output | 8 | MMU command byte |
| done_pop | output | 1 | Pop request for the completion queue |
| soft_rst | output | 1 | Soft reset pulse |

## Verification
The bench puts an auto-incrementing pointer just below the page end and runs a 32-bit data burst across it. If the carry leaked into bit 11, or the increment were applied to the whole word, the pointer read-back and the wrapped bytes would be wrong. It writes the same offset through both page selects and reads each back, which exposes an inverted select bit. It also reads the pointer high byte with bit 3 set, which a missing 0xF7 mask would return unchanged. A 32-bit write at offset 12 is checked to leave the mask unchanged, and an acknowledge is checked not to clear status bits 0 and 3. Sticky forced bits are checked after their source condition has gone away, and an early or dropped response is caught by latency counting and by holding `rsp_ready` low.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
  localparam int OFFS_W = 11;  // byte address bits inside a page

  typedef enum logic [1:0] {ST_IDLE, ST_OPA, ST_OPB, ST_RESP} seq_state_t;

  typedef struct packed {
    logic       wr;
    logic [3:0] addr;
    logic [7:0] wdata;
  } byte_op_t;

  localparam logic [15:0] CFG_RST  = 16'hA0B1;
  localparam logic [15:0] CTL_RST  = 16'h1210;
  localparam logic [7:0]  ERCV_RST = 8'h1F;
  localparam logic [7:0]  STAT_RST = 8'h04;
  localparam logic [7:0]  ACK_MASK = 8'hD6;
  localparam logic [7:0]  ID_BYTE  = 8'h33;
  localparam logic [7:0]  REV_BYTE = 8'h91;
  localparam logic [7:0]  EMPTY_PG = 8'h80;
  localparam logic [3:0]  OFF_BANK = 4'd14;
  localparam logic [3:0]  OFF_ID   = 4'd15;
endpackage

// File: rtl/bpw_ram.sv
module bpw_ram #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/bpw_seq.sv
module bpw_seq
  import bpw_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IW = $clog2(LANES),
  localparam int DW = LANES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [3:0]    req_addr,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          op_fire,
  output byte_op_t      op,
  input  logic [7:0]    rd_byte
);
  seq_state_t    st;
  logic [IW-1:0] idx, last;
  logic          wr_q;
  logic [3:0]    addr_q;
  logic [DW-1:0] wd_q, res_q;
  logic [IW-1:0] last_c, start_c;

  always_comb begin
    unique case (req_size)
      2'd0:    last_c = '0;
      2'd1:    last_c = IW'(1);
      default: last_c = IW'(LANES - 1);
    endcase
    // a full-word write at offset 12 lands only on the upper halfword
    start_c = (req_write && req_size[1] && req_addr == 4'hC) ? IW'(2) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      last   <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      res_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          wr_q   <= req_write;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          res_q  <= '0;
          last   <= last_c;
          idx    <= start_c;
          st     <= ST_OPA;
        end
        ST_OPA: st <= ST_OPB;
        ST_OPB: begin
          res_q[{idx, 3'b000} +: 8] <= rd_byte;
          if (idx == last) st <= ST_RESP;
          else begin
            idx <= idx + IW'(1);
            st  <= ST_OPA;
          end
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_rdata = res_q;
  assign op_fire   = (st == ST_OPA);
  assign op.wr     = wr_q;
  assign op.addr   = addr_q + 4'(idx);
  assign op.wdata  = wd_q[{idx, 3'b000} +: 8];
endmodule

// File: rtl/bpw_regs.sv
module bpw_regs
  import bpw_pkg::*;
#(
  parameter int NUM_PAGES = 2,
  localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int RAM_AW = PAGE_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_fire,
  input  byte_op_t          op,
  output logic [7:0]        rd_byte,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_q,
  input  logic [7:0]        rx_head,
  input  logic              rx_empty,
  input  logic [7:0]        done_head,
  input  logic              done_empty,
  input  logic [7:0]        alloc_result,
  input  logic              txq_empty,
  input  logic [7:0]        evt_set,
  input  logic [7:0]        evt_clr,
  output logic              irq,
  output logic              mmu_cmd_valid,
  output logic [7:0]        mmu_cmd,
  output logic              done_pop,
  output logic              soft_rst,
  output logic [7:0]        bank_o,
  output logic [15:0]       ptr_o,
  output logic [7:0]        stat_view_o
);
  logic [7:0]  bank_q, pnr_q, ercv_q, stat_q, mask_q, cap_q;
  logic [15:0] tcr_q, rcr_q, cfg_q, ctl_q, gpr_q, ptr_q;
  logic        from_mem_q;

  logic [1:0]        bsel;
  logic [3:0]        off;
  logic              wr_hit, rd_hit, is_data;
  logic [OFFS_W-1:0] byte_addr;
  logic [7:0]        page, forced, stat_view, ack_clr, rd_val;

  assign bsel    = bank_q[1:0];
  assign off     = op.addr;
  assign wr_hit  = op_fire && op.wr;
  assign rd_hit  = op_fire && !op.wr;
  assign is_data = (bsel == 2'd2) && (off[3:2] == 2'b10);

  assign byte_addr = ptr_q[14] ? ptr_q[OFFS_W-1:0]
                               : ptr_q[OFFS_W-1:0] + OFFS_W'(off[1:0]);
  assign page      = ptr_q[15] ? rx_head : pnr_q;
  assign ram_addr  = {page[PAGE_W-1:0], byte_addr};
  assign ram_we    = wr_hit && is_data;
  assign ram_wdata = op.wdata;

  assign forced    = {5'b0, txq_empty, ~done_empty, 1'b0};
  assign stat_view = stat_q | forced;
  assign irq       = |(stat_view & mask_q);

  assign soft_rst      = wr_hit && bsel == 2'd0 && off == 4'd5 && op.wdata[7];
  assign mmu_cmd_valid = wr_hit && bsel == 2'd2 && off == 4'd0;
  assign mmu_cmd       = op.wdata;
  assign done_pop      = wr_hit && bsel == 2'd2 && off == 4'd12 && op.wdata[1];
  assign ack_clr       = (wr_hit && bsel == 2'd2 && off == 4'd12) ? (op.wdata & ACK_MASK) : 8'h00;

  always_comb begin
    rd_val = 8'h00;
    if (off == OFF_BANK)    rd_val = bank_q;
    else if (off == OFF_ID) rd_val = ID_BYTE;
    else begin
      unique case (bsel)
        2'd0: unique case (off)
          4'd0:    rd_val = tcr_q[7:0];
          4'd1:    rd_val = tcr_q[15:8];
          4'd3:    rd_val = 8'h40;
          4'd4:    rd_val = rcr_q[7:0];
          4'd5:    rd_val = rcr_q[15:8];
          4'd8:    rd_val = 8'(NUM_PAGES);
          default: rd_val = 8'h00;
        endcase
        2'd1: unique case (off)
          4'd0:    rd_val = cfg_q[7:0];
          4'd1:    rd_val = cfg_q[15:8];
          4'd10:   rd_val = gpr_q[7:0];
          4'd11:   rd_val = gpr_q[15:8];
          4'd12:   rd_val = ctl_q[7:0];
          4'd13:   rd_val = ctl_q[15:8];
          default: rd_val = 8'h00;
        endcase
        2'd2: unique case (off)
          4'd2:    rd_val = pnr_q;
          4'd3:    rd_val = alloc_result;
          4'd4:    rd_val = done_empty ? EMPTY_PG : done_head;
          4'd5:    rd_val = rx_empty ? EMPTY_PG : rx_head;
          4'd6:    rd_val = ptr_q[7:0];
          4'd7:    rd_val = ptr_q[15:8] & 8'hF7;
          4'd12:   rd_val = stat_view;
          4'd13:   rd_val = mask_q;
          default: rd_val = 8'h00;
        endcase
        default: unique case (off)
          4'd8:    rd_val = 8'h30;
          4'd9:    rd_val = ID_BYTE;
          4'd10:   rd_val = REV_BYTE;
          4'd11:   rd_val = ID_BYTE;
          4'd12:   rd_val = ercv_q;
          default: rd_val = 8'h00;
        endcase
      endcase
    end
  end

  assign rd_byte = from_mem_q ? ram_q : cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q      <= '0;
      from_mem_q <= 1'b0;
    end else if (rd_hit) begin
      cap_q      <= rd_val;
      from_mem_q <= is_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;  pnr_q <= '0;  ercv_q <= ERCV_RST;
      stat_q <= STAT_RST;  mask_q <= '0;
      tcr_q <= '0;  rcr_q <= '0;  cfg_q <= CFG_RST;
      ctl_q <= CTL_RST;  gpr_q <= '0;  ptr_q <= '0;
    end else if (soft_rst) begin
      bank_q <= '0;  pnr_q <= '0;  ercv_q <= ERCV_RST;
      stat_q <= STAT_RST;  mask_q <= '0;
      tcr_q <= '0;  rcr_q <= '0;  cfg_q <= CFG_RST;
      ctl_q <= CTL_RST;  gpr_q <= '0;  ptr_q <= '0;
    end else begin
      stat_q <= ((stat_q | evt_set | forced) & ~ack_clr) & ~evt_clr;
      if (op_fire && is_data && ptr_q[14])
        ptr_q[OFFS_W-1:0] <= ptr_q[OFFS_W-1:0] + OFFS_W'(1);
      if (wr_hit) begin
        if (off == OFF_BANK) bank_q <= op.wdata;
        else begin
          unique case (bsel)
            2'd0: unique case (off)
              4'd0:    tcr_q[7:0]  <= op.wdata;
              4'd1:    tcr_q[15:8] <= op.wdata;
              4'd4:    rcr_q[7:0]  <= op.wdata;
              4'd5:    rcr_q[15:8] <= op.wdata;
              default: ;
            endcase
            2'd1: unique case (off)
              4'd0:    cfg_q[7:0]  <= op.wdata;
              4'd1:    cfg_q[15:8] <= op.wdata;
              4'd10:   gpr_q[7:0]  <= op.wdata;
              4'd11:   gpr_q[15:8] <= op.wdata;
              4'd12:   ctl_q[7:0]  <= op.wdata & 8'hFC;
              4'd13:   ctl_q[15:8] <= op.wdata;
              default: ;
            endcase
            2'd2: unique case (off)
              4'd2:    pnr_q        <= op.wdata;
              4'd6:    ptr_q[7:0]   <= op.wdata;
              4'd7:    ptr_q[15:8]  <= op.wdata;
              4'd13:   mask_q       <= op.wdata;
              default: ;
            endcase
            default: if (off == 4'd12) ercv_q <= op.wdata & 8'h1F;
          endcase
        end
      end
    end
  end

  assign bank_o      = bank_q;
  assign ptr_o       = ptr_q;
  assign stat_view_o = stat_view;
endmodule

// File: rtl/bufport_window.sv
module bufport_window
  import bpw_pkg::*;
#(
  parameter int NUM_PAGES = 2,
  parameter int LANES = 4,
  localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int RAM_AW = PAGE_W + OFFS_W,
  localparam int DW = LANES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [3:0]    req_addr,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  input  logic [7:0]    rx_head,
  input  logic          rx_empty,
  input  logic [7:0]    done_head,
  input  logic          done_empty,
  input  logic [7:0]    alloc_result,
  input  logic          txq_empty,
  input  logic [7:0]    evt_set,
  input  logic [7:0]    evt_clr,
  output logic          irq,
  output logic          mmu_cmd_valid,
  output logic [7:0]    mmu_cmd,
  output logic          done_pop,
  output logic          soft_rst
);
  logic              op_fire;
  byte_op_t          op;
  logic [7:0]        rd_byte, ram_wdata, ram_q, bank_w, stat_w;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [15:0]       ptr_w;

  bpw_seq #(.LANES(LANES)) u_seq (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_size,
    .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata,
    .op_fire(op_fire), .op(op), .rd_byte(rd_byte)
  );

  bpw_regs #(.NUM_PAGES(NUM_PAGES)) u_regs (
    .clk, .rst_n, .op_fire(op_fire), .op(op), .rd_byte(rd_byte),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_q(ram_q),
    .rx_head, .rx_empty, .done_head, .done_empty, .alloc_result, .txq_empty,
    .evt_set, .evt_clr, .irq, .mmu_cmd_valid, .mmu_cmd, .done_pop, .soft_rst,
    .bank_o(bank_w), .ptr_o(ptr_w), .stat_view_o(stat_w)
  );

  bpw_ram #(.DEPTH(NUM_PAGES << OFFS_W)) u_ram (
    .clk, .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_q)
  );
endmodule

// File: rtl/bpw_chk.sv
module bpw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        op_fire,
  input logic        op_wr,
  input logic [3:0]  op_addr,
  input logic [7:0]  bank,
  input logic [15:0] ptr,
  input logic [7:0]  stat_view,
  input logic        txq_empty,
  input logic        done_empty,
  input logic        done_pop,
  input logic        soft_rst
);
  logic data_acc;
  assign data_acc = op_fire && bank[1:0] == 2'd2 && op_addr[3:2] == 2'b10;

  p_id_write_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && op_wr && op_addr == 4'd15 && !soft_rst) |=> $stable(bank));

  p_autoinc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && ptr[14]) |=> (ptr[15:11] == $past(ptr[15:11]) &&
                               ptr[10:0] == $past(ptr[10:0]) + 11'd1));

  p_ptr_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ptr[14]) |=> $stable(ptr));

  p_ptr_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !op_fire |=> $stable(ptr));

  p_pop_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_pop |=> !done_pop);

  p_txe_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txq_empty |-> stat_view[2]);

  p_txd_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_empty |-> stat_view[1]);

  p_soft_defaults_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (bank == 8'h00 && ptr == 16'h0000));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind bufport_window bpw_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .op_fire(op_fire),
  .op_wr(op.wr), .op_addr(op.addr), .bank(bank_w), .ptr(ptr_w),
  .stat_view(stat_w), .txq_empty(txq_empty), .done_empty(done_empty),
  .done_pop(done_pop), .soft_rst(soft_rst)
);

// File: tb/bufport_window_tb.sv
module bufport_window_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  rx_head = 8'h00, done_head = 8'h00, alloc_result = 8'h00;
  logic        rx_empty = 1'b1, done_empty = 1'b1, txq_empty = 1'b1;
  logic [7:0]  evt_set = '0, evt_clr = '0;
  logic        irq, mmu_cmd_valid, done_pop, soft_rst;
  logic [7:0]  mmu_cmd;

  int n_chk = 0, n_fail = 0;
  int pops = 0, softs = 0, mmus = 0;
  logic [7:0] last_mmu = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bufport_window dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_size,
    .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .rx_head, .rx_empty,
    .done_head, .done_empty, .alloc_result, .txq_empty, .evt_set, .evt_clr,
    .irq, .mmu_cmd_valid, .mmu_cmd, .done_pop, .soft_rst
  );

  always @(negedge clk) begin
    if (done_pop) pops++;
    if (soft_rst) softs++;
    if (mmu_cmd_valid) begin mmus++; last_mmu = mmu_cmd; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input int hold,
                      output logic [31:0] rd, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_wdata = wd; rsp_ready = (hold == 0);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    rd = rsp_rdata;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk("R11 response held", {31'b0, rsp_valid}, 32'd1);
      chk("R11 response stable", rsp_rdata, rd);
      rsp_ready = 1'b1;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] r; int l;
    xfer(1'b1, a, sz, d, 0, r, l);
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] d);
    int l;
    xfer(1'b0, a, sz, 32'h0, 0, d, l);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'd14, 2'd0, v); chk("R9 bank after reset", v, 32'h0);
    chk("R9 irq low after reset", {31'b0, irq}, 32'h0);
    wr(4'd14, 2'd0, 32'h1);
    rd(4'd0, 2'd1, v);  chk("R9 config reset", v, 32'h0000A0B1);
    rd(4'd12, 2'd1, v); chk("R9 control reset", v, 32'h00001210);
    wr(4'd14, 2'd0, 32'h3);
    rd(4'd12, 2'd0, v); chk("R9 early-receive reset", v, 32'h1F);
    wr(4'd14, 2'd0, 32'h2);
    rd(4'd12, 2'd0, v); chk("R9 status reset", v, 32'h04);
    rd(4'd13, 2'd0, v); chk("R9 mask reset", v, 32'h00);
  endtask

  task automatic t_bank;
    logic [31:0] v;
    wr(4'd14, 2'd0, 32'h3);
    rd(4'd14, 2'd0, v); chk("R1 bank readback", v, 32'h3);
    wr(4'd15, 2'd0, 32'hAA);
    rd(4'd15, 2'd0, v); chk("R1 offset 15 constant", v, 32'h33);
    rd(4'd14, 2'd0, v); chk("R1 bank unchanged by offset 15 write", v, 32'h3);
    rd(4'd10, 2'd0, v); chk("R1 bank 3 selected", v, 32'h91);
  endtask

  task automatic t_autoinc;
    logic [31:0] v;
    wr(4'd14, 2'd0, 32'h2);
    wr(4'd2, 2'd0, 32'h1);
    wr(4'd6, 2'd1, 32'h47FE);
    wr(4'd8, 2'd2, 32'h44332211);
    rd(4'd6, 2'd1, v); chk("R3 pointer wrapped in page", v, 32'h4002);
    wr(4'd6, 2'd1, 32'h07FE);
    rd(4'd8, 2'd2, v); chk("R4 offset-added read wraps", v, 32'h44332211);
    rd(4'd6, 2'd1, v); chk("R4 pointer unchanged", v, 32'h07FE);
    wr(4'd6, 2'd1, 32'h0000);
    rd(4'd9, 2'd0, v); chk("R4 offset 9 adds one", v, 32'h44);
  endtask

  task automatic t_page;
    logic [31:0] v;
    rx_head = 8'h00;
    wr(4'd6, 2'd1, 32'hC000);
    wr(4'd8, 2'd0, 32'hA5);
    wr(4'd6, 2'd1, 32'h0000);
    rd(4'd8, 2'd0, v); chk("R2 packet-number page", v, 32'h33);
    wr(4'd6, 2'd1, 32'h8000);
    rd(4'd8, 2'd0, v); chk("R2 receive-head page", v, 32'hA5);
  endtask

  task automatic t_ptr_mask;
    logic [31:0] v;
    wr(4'd6, 2'd1, 32'h0812);
    rd(4'd6, 2'd1, v); chk("R5 high byte bit 3 masked", v, 32'h0012);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(4'd13, 2'd0, 32'h04);
    chk("R7 irq from tx-empty", {31'b0, irq}, 32'h1);
    txq_empty = 1'b0;
    wr(4'd12, 2'd0, 32'h04);
    rd(4'd12, 2'd0, v); chk("R6 ack clears bit 2", v, 32'h00);
    chk("R7 irq drops", {31'b0, irq}, 32'h0);
    done_empty = 1'b0;
    wr(4'd13, 2'd0, 32'h02);
    chk("R7 irq from completion", {31'b0, irq}, 32'h1);
    wr(4'd12, 2'd0, 32'h02);
    chk("R6 pop pulse", pops, 1);
    done_empty = 1'b1;
    rd(4'd12, 2'd0, v); chk("R7 bit 1 sticky", v, 32'h02);
    wr(4'd12, 2'd0, 32'h02);
    rd(4'd12, 2'd0, v); chk("R6 second ack clears", v, 32'h00);
    chk("R7 irq low", {31'b0, irq}, 32'h0);
    @(negedge clk); evt_set = 8'h09; @(negedge clk); evt_set = 8'h00;
    rd(4'd12, 2'd0, v); chk("R13 event set", v, 32'h09);
    wr(4'd12, 2'd0, 32'hFF);
    rd(4'd12, 2'd0, v); chk("R6 ack spares bits 0 and 3", v, 32'h09);
    chk("R6 pop count", pops, 3);
    @(negedge clk); evt_clr = 8'h09; @(negedge clk); evt_clr = 8'h00;
    rd(4'd12, 2'd0, v); chk("R13 event clear", v, 32'h00);
  endtask

  task automatic t_wide;
    logic [31:0] v;
    wr(4'd12, 2'd2, 32'h0001FF00);
    rd(4'd14, 2'd0, v); chk("R8 word write at 12 reaches bank", v, 32'h1);
    rd(4'd14, 2'd1, v); chk("R8 halfword order", v, 32'h3301);
    wr(4'd14, 2'd0, 32'h2);
    rd(4'd13, 2'd0, v); chk("R8 mask untouched", v, 32'h02);
    rd(4'd12, 2'd2, v); chk("R8 word read wraps", v, 32'h33020200);
  endtask

  task automatic t_mmu;
    logic [31:0] v;
    wr(4'd0, 2'd0, 32'h40);
    chk("R12 mmu pulse", mmus, 1);
    chk("R12 mmu byte", last_mmu, 32'h40);
    wr(4'd14, 2'd0, 32'h1);
    wr(4'd12, 2'd0, 32'hFF);
    rd(4'd12, 2'd1, v); chk("R12 control low masked", v, 32'h12FC);
    wr(4'd14, 2'd0, 32'h3);
    wr(4'd12, 2'd0, 32'hFF);
    rd(4'd12, 2'd0, v); chk("R12 early-receive 5 bits", v, 32'h1F);
  endtask

  task automatic t_soft;
    logic [31:0] v;
    wr(4'd14, 2'd0, 32'h1);
    wr(4'd0, 2'd1, 32'h1234);
    rd(4'd0, 2'd1, v); chk("R10 config written", v, 32'h1234);
    wr(4'd14, 2'd0, 32'h0);
    wr(4'd4, 2'd1, 32'h8000);
    chk("R10 soft reset pulse", softs, 1);
    rd(4'd14, 2'd0, v); chk("R10 bank cleared", v, 32'h0);
    rd(4'd4, 2'd1, v); chk("R10 receive control cleared", v, 32'h0);
    wr(4'd14, 2'd0, 32'h1);
    rd(4'd0, 2'd1, v); chk("R10 config restored", v, 32'hA0B1);
  endtask

  task automatic t_latency;
    logic [31:0] v; int l;
    wr(4'd14, 2'd0, 32'h3);
    xfer(1'b0, 4'd8, 2'd2, 32'h0, 0, v, l);
    chk("R11 word latency", l, 8);
    chk("R11 constants", v, 32'h33913330);
    xfer(1'b0, 4'd10, 2'd0, 32'h0, 3, v, l);
    chk("R11 byte latency", l, 2);
    chk("R11 held data", v, 32'h91);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bank();
    t_autoinc();
    t_page();
    t_ptr_mask();
    t_irq();
    t_wide();
    t_mmu();
    t_soft();
    t_latency();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule